// File: doc/BRIEF.md
# Signed Three-Digit Decimal Adder

This block adds two signed decimal numbers held in sign-plus-magnitude form, each made of three binary-coded decimal digits and a sign flag. It is purely combinational. The result and an overflow flag follow the operands within the same evaluation, with no clock.

Inside, a magnitude comparator decides which operand is larger. A small control stage then picks addition or subtraction, decides whether to exchange the operands, and sets the provisional sign. The datapath is a chain of identical digit cells linked by a carry/borrow signal. Each cell does a plain binary add or subtract and then applies a decimal correction when the raw value leaves the range 0..9. The cells can only form A minus B, so the larger magnitude is always steered to the A side before subtraction. A final stage forces a zero result positive.

Top module: `sbcd_adder`

## Requirements
- R1: Each 13-bit operand and the result use bit 12 as the sign (0 positive, 1 negative), bits 11:8 as hundreds, bits 7:4 as tens and bits 3:0 as units. When both signs are equal, the result magnitude is the decimal sum and the result sign is the common sign, unless the result is zero.
- R2: When the signs differ, the result magnitude is the larger magnitude minus the smaller. The result sign is the sign of the operand with the larger magnitude. This holds whichever port carries the larger magnitude.
- R3: The overflow output is 1 exactly when the signs are equal and the magnitude sum exceeds 999. In that case the result digits are the low three decimal digits of the sum, and the sign is the common sign.
- R4: A result whose magnitude is 000 without overflow always has sign bit 0. This covers equal magnitudes with opposite signs and the sum of two negative zeros.
- R5: When the operand signs differ, the overflow output is always 0.
- R6: Decimal carries and borrows ripple across all digit positions. Examples: 999+001 gives 000 with overflow, and 100-001 gives 099. Every result digit is a valid decimal digit (0..9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 13 | First operand, sign and three decimal digits |
| b_i | input | 13 | Second operand, sign and three decimal digits |
| sum_o | output | 13 | Signed decimal result |
| ovf_o | output | 1 | Magnitude of result exceeds three digits |

## Verification
The operand exchange and a borrow rippling through every digit cell can occur in the same evaluation. The bench provokes this with opposite-sign pairs where B is larger and carries smaller low digits than A, for example +001 against -100. Overflow and the zero-sign rule can also coincide: -500 plus -500 wraps to digits 000 with overflow and must keep its negative sign, while +500 plus -500 gives 000 that must be positive. Each case is judged against an integer model of the signed sum that the scoreboard computes independently.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;

    localparam int DIG_W   = 4;
    localparam int N_DIG   = 3;
    localparam int DEC_MAX = 9;
    localparam int RADIX   = 10;

    typedef logic [DIG_W-1:0] digit_t;

    // relation between the two magnitudes
    typedef enum logic [1:0] {
        MAG_EQ   = 2'b00,
        MAG_A_GT = 2'b01,
        MAG_B_GT = 2'b10
    } mag_rel_e;

    typedef enum logic {
        DOP_ADD = 1'b0,
        DOP_SUB = 1'b1
    } dop_e;

    // decisions produced by the control stage
    typedef struct packed {
        dop_e op;
        logic swap;
        logic neg;
    } plan_t;

    // correction applied when an add leaves the decimal range
    localparam digit_t ADD_FIX = digit_t'((1 << DIG_W) - RADIX);
    // correction applied when a subtract borrows
    localparam digit_t SUB_FIX = digit_t'(RADIX);

    function automatic mag_rel_e rel_step(input digit_t a, input digit_t b,
                                          input mag_rel_e lower);
        if (a > b)      return MAG_A_GT;
        else if (a < b) return MAG_B_GT;
        else            return lower;
    endfunction

endpackage

// File: rtl/sbcd_mag_cmp.sv
module sbcd_mag_cmp
    import sbcd_pkg::*;
#(
    parameter int NDIG = N_DIG
) (
    input  digit_t   [NDIG-1:0] a_mag,
    input  digit_t   [NDIG-1:0] b_mag,
    output mag_rel_e            rel
);
    // chain runs from the least significant digit upward, so the most
    // significant differing digit has the last word
    mag_rel_e chain [NDIG+1];

    assign chain[0] = MAG_EQ;

    for (genvar g = 0; g < NDIG; g++) begin : g_cmp
        assign chain[g+1] = rel_step(a_mag[g], b_mag[g], chain[g]);
    end

    assign rel = chain[NDIG];
endmodule

// File: rtl/sbcd_ctl.sv
module sbcd_ctl
    import sbcd_pkg::*;
(
    input  logic     a_neg,
    input  logic     b_neg,
    input  mag_rel_e rel,
    output plan_t    plan
);
    always_comb begin
        plan = '{op: DOP_ADD, swap: 1'b0, neg: a_neg};
        if (a_neg != b_neg) begin
            plan.op = DOP_SUB;
            unique case (rel)
                MAG_B_GT: begin
                    plan.swap = 1'b1;
                    plan.neg  = b_neg;
                end
                MAG_A_GT: plan.neg = a_neg;
                default:  plan.neg = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sbcd_digit_cell.sv
module sbcd_digit_cell
    import sbcd_pkg::*;
(
    input  digit_t a,
    input  digit_t b,
    input  dop_e   op,
    input  logic   ci,
    output digit_t d,
    output logic   co
);
    logic [DIG_W:0] raw;

    always_comb begin
        if (op == DOP_ADD) begin
            raw = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, ci};
            co  = (raw > (DIG_W+1)'(DEC_MAX));
            d   = co ? (raw[DIG_W-1:0] + ADD_FIX) : raw[DIG_W-1:0];
        end else begin
            raw = {1'b0, a} - {1'b0, b} - {{DIG_W{1'b0}}, ci};
            co  = raw[DIG_W];
            d   = co ? (raw[DIG_W-1:0] + SUB_FIX) : raw[DIG_W-1:0];
        end
    end
endmodule

// File: rtl/sbcd_ripple.sv
module sbcd_ripple
    import sbcd_pkg::*;
#(
    parameter int NDIG = N_DIG
) (
    input  digit_t [NDIG-1:0] x,
    input  digit_t [NDIG-1:0] y,
    input  dop_e              op,
    output digit_t [NDIG-1:0] r,
    output logic              co
);
    logic [NDIG:0] cy;

    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NDIG; g++) begin : g_cell
        sbcd_digit_cell u_cell (
            .a  (x[g]),
            .b  (y[g]),
            .op (op),
            .ci (cy[g]),
            .d  (r[g]),
            .co (cy[g+1])
        );
    end

    assign co = cy[NDIG];
endmodule

// File: rtl/sbcd_adder.sv
module sbcd_adder
    import sbcd_pkg::*;
#(
    parameter int NDIG = N_DIG,
    localparam int W   = NDIG*DIG_W + 1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    digit_t [NDIG-1:0] a_mag, b_mag, x_mag, y_mag, r_mag;
    mag_rel_e          rel;
    plan_t             plan;
    logic              chain_co;
    logic              mag_zero;

    assign a_mag = a_i[W-2:0];
    assign b_mag = b_i[W-2:0];

    sbcd_mag_cmp #(.NDIG(NDIG)) u_cmp (
        .a_mag (a_mag),
        .b_mag (b_mag),
        .rel   (rel)
    );

    sbcd_ctl u_ctl (
        .a_neg (a_i[W-1]),
        .b_neg (b_i[W-1]),
        .rel   (rel),
        .plan  (plan)
    );

    // larger magnitude goes to the minuend side
    assign x_mag = plan.swap ? b_mag : a_mag;
    assign y_mag = plan.swap ? a_mag : b_mag;

    sbcd_ripple #(.NDIG(NDIG)) u_path (
        .x  (x_mag),
        .y  (y_mag),
        .op (plan.op),
        .r  (r_mag),
        .co (chain_co)
    );

    assign ovf_o    = (plan.op == DOP_ADD) && chain_co;
    assign mag_zero = (r_mag == '0);
    assign sum_o    = {plan.neg & ~(mag_zero & ~ovf_o), r_mag};
endmodule

// File: rtl/sbcd_adder_chk.sv
module sbcd_adder_chk
    import sbcd_pkg::*;
#(
    parameter int NDIG = N_DIG,
    localparam int W   = NDIG*DIG_W + 1
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] sum_o,
    input logic         ovf_o
);
    function automatic int unsigned mag_val(input logic [W-1:0] v);
        int unsigned acc = 0;
        for (int k = NDIG-1; k >= 0; k--)
            acc = acc*RADIX + int'(v[k*DIG_W +: DIG_W]);
        return acc;
    endfunction

    function automatic logic digits_ok(input logic [W-1:0] v);
        logic ok = 1'b1;
        for (int k = 0; k < NDIG; k++)
            if (v[k*DIG_W +: DIG_W] > digit_t'(DEC_MAX)) ok = 1'b0;
        return ok;
    endfunction

    int unsigned lim;
    logic same_sgn, in_ok;

    always_comb begin
        lim = 1;
        for (int k = 0; k < NDIG; k++) lim = lim*RADIX;
        same_sgn = (a_i[W-1] == b_i[W-1]);
        in_ok    = digits_ok(a_i) && digits_ok(b_i);
        if (in_ok) begin
            AST_NO_OVERFLOW: assert (same_sgn || !ovf_o);  // R5
            AST_OVF_EXACT: assert (ovf_o == (same_sgn && (mag_val(a_i) + mag_val(b_i) >= lim)));  // R3
            AST_ZERO_POS: assert (!(sum_o[W-2:0] == '0 && !ovf_o) || !sum_o[W-1]);  // R4
            AST_DIGITS_VALID: assert (digits_ok(sum_o));  // R6
            AST_LIKE_SIGN: assert (!(same_sgn && sum_o[W-2:0] != '0) || sum_o[W-1] == a_i[W-1]);  // R1
            AST_LARGER_SIGN: assert (same_sgn || mag_val(a_i) == mag_val(b_i) || sum_o[W-1] == ((mag_val(a_i) > mag_val(b_i)) ? a_i[W-1] : b_i[W-1]));  // R2
        end
    end
endmodule

bind sbcd_adder sbcd_adder_chk #(.NDIG(NDIG)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o),
    .ovf_o (ovf_o)
);

// File: tb/sim_sbcd_adder.sv
module sim_sbcd_adder;
    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, s;
    logic         ov;
    int           n_chk = 0, n_err = 0;
    bit           done = 1'b0;

    typedef struct {
        logic [W-1:0] a, b, s;
        logic         ov;
        string        req;
    } item_t;
    item_t sb [$];

    always #5 clk = ~clk;

    sbcd_adder u0 (.a_i(a), .b_i(b), .sum_o(s), .ovf_o(ov));

    function automatic logic [W-1:0] enc(input bit neg, input int m);
        return {neg, 4'(m/100), 4'((m/10)%10), 4'(m%10)};
    endfunction

    function automatic int dec(input logic [W-1:0] v);
        return int'(v[11:8])*100 + int'(v[7:4])*10 + int'(v[3:0]);
    endfunction

    // independent integer model of the requirements
    task automatic drive(input bit sa, input int ma, input bit sb_, input int mb,
                         input string req);
        item_t it;
        int va, vb, t, mg;
        bit ng;
        va = sa ? -ma : ma;
        vb = sb_ ? -mb : mb;
        t  = va + vb;
        it.ov = (sa == sb_) && (ma + mb > 999);
        if (it.ov) begin
            mg = (ma + mb) % 1000;
            ng = sa;
        end else begin
            mg = (t < 0) ? -t : t;
            ng = (t < 0);
        end
        @(posedge clk);
        #1;
        a = enc(sa, ma);
        b = enc(sb_, mb);
        it.a = a; it.b = b; it.s = enc(ng, mg); it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compare away from the driving edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            n_chk++;
            if (s !== e.s || ov !== e.ov) begin
                n_err++;
                $display("FAIL %s: a=%h b=%h got sum=%h ovf=%b expected sum=%h ovf=%b",
                         e.req, e.a, e.b, s, ov, e.s, e.ov);
            end
        end
    end

    initial begin
        a = '0; b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (s !== '0 || ov !== 1'b0) begin
            n_err++;
            $display("FAIL R4 idle: got sum=%h ovf=%b expected sum=0000 ovf=0", s, ov);
        end
        rst = 1'b0;

        drive(0, 123, 0, 456, "R1");
        drive(1, 250, 1, 349, "R1");
        drive(0, 58,  0, 67,  "R6");
        drive(0, 999, 0, 1,   "R6");
        drive(1, 100, 0, 1,   "R6");
        drive(0, 100, 1, 1,   "R6");
        drive(0, 1,   1, 100, "R2");
        drive(1, 7,   0, 300, "R2");
        drive(0, 456, 1, 123, "R2");
        drive(0, 500, 0, 500, "R3");
        drive(1, 500, 1, 500, "R3");
        drive(1, 999, 1, 999, "R3");
        drive(0, 998, 0, 1,   "R3");
        drive(0, 500, 1, 500, "R4");
        drive(1, 321, 0, 321, "R4");
        drive(1, 0,   1, 0,   "R4");
        drive(0, 0,   1, 0,   "R4");
        drive(0, 999, 1, 999, "R5");
        drive(1, 0,   0, 999, "R5");
        for (int i = 0; i < 400; i++)
            drive(1'($urandom), int'($urandom % 1000), 1'($urandom),
                  int'($urandom % 1000), "R1_R2_R3");
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung run expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule